// File: doc/BRIEF.md
# Power-Mode Supervisor

This block is the mode controller of a chip that supplies a microcontroller and a serial bus. It moves between five operating modes: Off, Standby, Normal, Sleep and Overtemp. Its inputs are digitised threshold flags from the battery and temperature comparators, a two-bit mode request field, the level of the interrupt line, the wake-up enables, the wake-up pending flag, the wake-up events, and the two reset sources (watchdog overflow and regulator undervoltage). Its outputs are the current mode, the regulator enable, the state of the bus transceiver, the watchdog operating mode, a timed reset output, the limp-home output and a signal that holds the interrupt line high.

Conditions are ranked when they occur together. Battery loss wins, then overtemperature, then a reset event, then the mode request. Every entry into Standby that restarts the system starts a reset pulse. That covers power-up, wake-up, the end of an overtemperature, and a reset event in Normal. The pulse runs for one of two parameterised lengths, chosen by a configuration input. A request for Sleep that does not meet its entry guard is ignored.

Top module: `pwr_supervisor`

## Requirements
- R1: During and after an asynchronous reset (`rst_n` low) the block is in Off. Mode codes are Off=0, Standby=1, Normal=2, Sleep=3, Overtemp=4. In Off the regulator is disabled, the bus is off and high-impedance, the watchdog is off, the reset output is low, `int_hold_hi` is 1 and `limp_n` is 1.
- R2: From any mode, `bat_below_off` high moves the block to Off at the next clock edge. This condition takes priority over every other input.
- R3: In Off, `bat_above_on` high moves the block to Standby at the next edge. `rst_out_n` then stays low for exactly RST_LONG_CYC cycles when `rst_long_sel`=1, or RST_SHORT_CYC cycles when it is 0, counted from the entry edge. After that it goes high.
- R4: In Standby, `mode_req`=10 or 11 moves the block to Normal. In Normal, `mode_req`=00 moves it to Standby. Neither change produces a reset pulse.
- R5: `mode_req`=01 in Standby or Normal enters Sleep only when `int_line` is 1, at least one bit of `wake_en` is set and `wake_pend` is 0. If any of these conditions fails, the request is ignored and the mode does not change.
- R6: In Sleep the regulator is off, `rst_out_n` is low and the watchdog is off. A wake event on a bit whose enable is set returns the block to Standby with a reset pulse. Events on disabled bits are ignored.
- R7: In Normal, `wdog_ovf` or `reg_uv` moves the block to Standby with a reset pulse. This takes priority over `mode_req`.
- R8: In Standby or Normal, `temp_above_act` moves the block to Overtemp. This takes priority over reset events and over `mode_req`. In Overtemp the regulator is off, the bus is off and high-impedance, the watchdog is off and `limp_n` is 0.
- R9: Overtemp is left only when `temp_below_rel` is high (or when the battery fails, as in R2). It then goes to Standby with a reset pulse.
- R10: Bus codes are Active=0, Low-power=1, Off=2, Off-high-impedance=3. In Standby and Sleep the bus is Low-power when `bus_lp_sel`=1 and Off when it is 0. In Normal the bus is Low-power when `bus_lp_sel`=1 and Active when it is 0.
- R11: Watchdog codes are Off=0, Timeout=1, Window=2. In Standby the watchdog is Timeout when `wd_dis` is 0 and `wd_run_sel` is 1, and Off otherwise. In Normal it is Off when `wd_dis` is 1. Otherwise `wd_norm_sel` selects it: 00 Off, 01 Timeout, 1x Window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bat_below_off | input | 1 | Battery below the power-off threshold |
| bat_above_on | input | 1 | Battery above the power-on threshold |
| temp_above_act | input | 1 | Temperature above the overtemperature activation threshold |
| temp_below_rel | input | 1 | Temperature below the overtemperature release threshold |
| mode_req | input | 2 | Mode request field |
| int_line | input | 1 | Interrupt line level (1 = idle) |
| wake_en | input | WAKE_W | Wake source enables (bit 0 bus, bit 1 local) |
| wake_pend | input | 1 | A wake-up is pending |
| wake_evt | input | WAKE_W | Wake events per source |
| wdog_ovf | input | 1 | Watchdog overflow reset source |
| reg_uv | input | 1 | Regulator undervoltage reset source |
| bus_lp_sel | input | 1 | Bus low-power select |
| wd_dis | input | 1 | Watchdog disable pin |
| wd_run_sel | input | 1 | Watchdog run select for Standby |
| wd_norm_sel | input | 2 | Watchdog mode select for Normal |
| rst_long_sel | input | 1 | 1 = long reset pulse, 0 = short |
| mode_o | output | 3 | Current mode code |
| reg_en | output | 1 | Regulator enable |
| bus_state | output | 2 | Bus transceiver state code |
| wd_mode | output | 2 | Watchdog mode code |
| rst_out_n | output | 1 | System reset output, active low |
| limp_n | output | 1 | Limp-home output, active low |
| int_hold_hi | output | 1 | Holds the interrupt output high |

## Verification
The assertions check on every cycle that battery loss forces Off and that each mode's outputs (regulator, reset, limp-home, bus, watchdog) agree with it. They also check that no mode is entered without its guard. This covers battery priority, the Sleep entry guard, the Overtemp exit condition, and the reset-event and wake paths into Standby with the reset output held low. Only the bench's scenarios can show the exact length of each reset pulse for both length settings and the pulse-free mode-request paths. They also show how priorities resolve when several conditions are raised in the same cycle, and the full mapping from configuration bits to the bus and watchdog codes.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

   typedef enum logic [2:0] {
      M_OFF      = 3'd0,
      M_STANDBY  = 3'd1,
      M_NORMAL   = 3'd2,
      M_SLEEP    = 3'd3,
      M_OVERTEMP = 3'd4
   } mode_e;

   typedef enum logic [1:0] {
      BUS_ACTIVE = 2'd0,
      BUS_LOWPWR = 2'd1,
      BUS_OFF    = 2'd2,
      BUS_HIZ    = 2'd3
   } bus_e;

   typedef enum logic [1:0] {
      WD_OFF     = 2'd0,
      WD_TIMEOUT = 2'd1,
      WD_WINDOW  = 2'd2
   } wd_e;

   typedef struct packed {
      logic       reg_en;
      bus_e       bus;
      wd_e        wd;
      logic       limp_n;
      logic       int_hi;
   } mode_out_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_sup_pkg::*;
#(
   parameter int WAKE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bat_below_off,
   input  logic              bat_above_on,
   input  logic              temp_above_act,
   input  logic              temp_below_rel,
   input  logic [1:0]        mode_req,
   input  logic              int_line,
   input  logic [WAKE_W-1:0] wake_en,
   input  logic              wake_pend,
   input  logic [WAKE_W-1:0] wake_evt,
   input  logic              wdog_ovf,
   input  logic              reg_uv,
   output mode_e             mode_q,
   output logic              pulse_start
);

   mode_e mode_d;
   logic  sleep_ok;
   logic  reset_evt;
   logic  wake_hit;

   assign sleep_ok  = int_line && (|wake_en) && !wake_pend;
   assign reset_evt = wdog_ovf || reg_uv;
   assign wake_hit  = |(wake_en & wake_evt);

   always_comb begin
      mode_d      = mode_q;
      pulse_start = 1'b0;
      if (bat_below_off) begin
         mode_d = M_OFF;
      end else begin
         unique case (mode_q)
            M_OFF: begin
               if (bat_above_on) begin
                  mode_d      = M_STANDBY;
                  pulse_start = 1'b1;
               end
            end
            M_STANDBY: begin
               if (temp_above_act) begin
                  mode_d = M_OVERTEMP;
               end else if (mode_req[1]) begin
                  mode_d = M_NORMAL;
               end else if (mode_req == 2'b01 && sleep_ok) begin
                  mode_d = M_SLEEP;
               end
            end
            M_NORMAL: begin
               if (temp_above_act) begin
                  mode_d = M_OVERTEMP;
               end else if (reset_evt) begin
                  mode_d      = M_STANDBY;
                  pulse_start = 1'b1;
               end else if (mode_req == 2'b00) begin
                  mode_d = M_STANDBY;
               end else if (mode_req == 2'b01 && sleep_ok) begin
                  mode_d = M_SLEEP;
               end
            end
            M_SLEEP: begin
               if (wake_hit) begin
                  mode_d      = M_STANDBY;
                  pulse_start = 1'b1;
               end
            end
            M_OVERTEMP: begin
               if (temp_below_rel) begin
                  mode_d      = M_STANDBY;
                  pulse_start = 1'b1;
               end
            end
            default: mode_d = M_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_OFF;
      end else begin
         mode_q <= mode_d;
      end
   end

endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
   parameter int LONG_CYC  = 20,
   parameter int SHORT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_sel,
   output logic busy
);

   localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(LONG_CYC);
   localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(SHORT_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= long_sel ? LOAD_LONG : LOAD_SHORT;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
   import pwr_sup_pkg::*;
(
   input  mode_e       mode,
   input  logic        bus_lp_sel,
   input  logic        wd_dis,
   input  logic        wd_run_sel,
   input  logic [1:0]  wd_norm_sel,
   output mode_out_t   outs
);

   wd_e norm_wd;

   always_comb begin
      if (wd_dis) begin
         norm_wd = WD_OFF;
      end else begin
         unique case (wd_norm_sel)
            2'b00:   norm_wd = WD_OFF;
            2'b01:   norm_wd = WD_TIMEOUT;
            default: norm_wd = WD_WINDOW;
         endcase
      end
   end

   always_comb begin
      outs = '{reg_en: 1'b0, bus: BUS_HIZ, wd: WD_OFF, limp_n: 1'b1, int_hi: 1'b0};
      unique case (mode)
         M_OFF: begin
            outs.int_hi = 1'b1;
         end
         M_STANDBY: begin
            outs.reg_en = 1'b1;
            outs.bus    = bus_lp_sel ? BUS_LOWPWR : BUS_OFF;
            outs.wd     = (!wd_dis && wd_run_sel) ? WD_TIMEOUT : WD_OFF;
         end
         M_NORMAL: begin
            outs.reg_en = 1'b1;
            outs.bus    = bus_lp_sel ? BUS_LOWPWR : BUS_ACTIVE;
            outs.wd     = norm_wd;
         end
         M_SLEEP: begin
            outs.bus    = bus_lp_sel ? BUS_LOWPWR : BUS_OFF;
         end
         M_OVERTEMP: begin
            outs.limp_n = 1'b0;
         end
         default: outs.int_hi = 1'b1;
      endcase
   end

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
   import pwr_sup_pkg::*;
#(
   parameter int WAKE_W        = 2,
   parameter int RST_LONG_CYC  = 20,
   parameter int RST_SHORT_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bat_below_off,
   input  logic              bat_above_on,
   input  logic              temp_above_act,
   input  logic              temp_below_rel,
   input  logic [1:0]        mode_req,
   input  logic              int_line,
   input  logic [WAKE_W-1:0] wake_en,
   input  logic              wake_pend,
   input  logic [WAKE_W-1:0] wake_evt,
   input  logic              wdog_ovf,
   input  logic              reg_uv,
   input  logic              bus_lp_sel,
   input  logic              wd_dis,
   input  logic              wd_run_sel,
   input  logic [1:0]        wd_norm_sel,
   input  logic              rst_long_sel,
   output logic [2:0]        mode_o,
   output logic              reg_en,
   output logic [1:0]        bus_state,
   output logic [1:0]        wd_mode,
   output logic              rst_out_n,
   output logic              limp_n,
   output logic              int_hold_hi
);

   generate
      if (WAKE_W < 1) begin : g_bad_wake
         $error("WAKE_W must be at least 1");
      end
      if (RST_SHORT_CYC < 1 || RST_LONG_CYC <= RST_SHORT_CYC) begin : g_bad_pulse
         $error("reset pulse lengths must satisfy 1 <= SHORT < LONG");
      end
   endgenerate

   mode_e     mode_q;
   logic      pulse_start;
   logic      pulse_busy;
   mode_out_t outs;

   pwr_mode_fsm #(.WAKE_W(WAKE_W)) i_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .bat_below_off  (bat_below_off),
      .bat_above_on   (bat_above_on),
      .temp_above_act (temp_above_act),
      .temp_below_rel (temp_below_rel),
      .mode_req       (mode_req),
      .int_line       (int_line),
      .wake_en        (wake_en),
      .wake_pend      (wake_pend),
      .wake_evt       (wake_evt),
      .wdog_ovf       (wdog_ovf),
      .reg_uv         (reg_uv),
      .mode_q         (mode_q),
      .pulse_start    (pulse_start)
   );

   pwr_rst_timer #(
      .LONG_CYC  (RST_LONG_CYC),
      .SHORT_CYC (RST_SHORT_CYC)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (pulse_start),
      .long_sel (rst_long_sel),
      .busy     (pulse_busy)
   );

   pwr_out_map i_map (
      .mode        (mode_q),
      .bus_lp_sel  (bus_lp_sel),
      .wd_dis      (wd_dis),
      .wd_run_sel  (wd_run_sel),
      .wd_norm_sel (wd_norm_sel),
      .outs        (outs)
   );

   assign mode_o      = mode_q;
   assign reg_en      = outs.reg_en;
   assign bus_state   = outs.bus;
   assign wd_mode     = outs.wd;
   assign limp_n      = outs.limp_n;
   assign int_hold_hi = outs.int_hi;
   assign rst_out_n   = outs.reg_en && !pulse_busy;

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
   parameter int WAKE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bat_below_off,
   input logic              temp_above_act,
   input logic              temp_below_rel,
   input logic [1:0]        mode_req,
   input logic              int_line,
   input logic [WAKE_W-1:0] wake_en,
   input logic              wake_pend,
   input logic [WAKE_W-1:0] wake_evt,
   input logic              wdog_ovf,
   input logic              reg_uv,
   input logic [2:0]        mode_o,
   input logic              reg_en,
   input logic [1:0]        bus_state,
   input logic [1:0]        wd_mode,
   input logic              rst_out_n,
   input logic              limp_n,
   input logic              int_hold_hi
);

   assert_off_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 3'd0 |-> (!reg_en && bus_state == 2'd3 && wd_mode == 2'd0
                          && !rst_out_n && int_hold_hi && limp_n));

   assert_bat_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bat_below_off |=> mode_o == 3'd0);

   assert_sleep_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 3'd3 && !(int_line && (|wake_en) && !wake_pend)) |=> mode_o != 3'd3);

   assert_sleep_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 3'd3 |-> (!reg_en && !rst_out_n && wd_mode == 2'd0));

   assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3 && !bat_below_off && (|(wake_en & wake_evt)))
      |=> (mode_o == 3'd1 && !rst_out_n));

   assert_rst_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 && !bat_below_off && !temp_above_act && (wdog_ovf || reg_uv))
      |=> (mode_o == 3'd1 && !rst_out_n));

   assert_ot_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 3'd4 |-> (!reg_en && !limp_n && bus_state == 2'd3 && wd_mode == 2'd0));

   assert_ot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && !bat_below_off && !temp_below_rel) |=> mode_o == 3'd4);

   assert_ot_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && !bat_below_off && temp_below_rel) |=> (mode_o == 3'd1 && !rst_out_n));

   assert_limp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !limp_n |-> mode_o == 3'd4);

   always_comb begin
      if (rst_n) begin
         assert_mode_legal_R1: assert (mode_o <= 3'd4);
      end
   end

endmodule

bind pwr_supervisor pwr_supervisor_chk #(.WAKE_W(WAKE_W)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bat_below_off  (bat_below_off),
   .temp_above_act (temp_above_act),
   .temp_below_rel (temp_below_rel),
   .mode_req       (mode_req),
   .int_line       (int_line),
   .wake_en        (wake_en),
   .wake_pend      (wake_pend),
   .wake_evt       (wake_evt),
   .wdog_ovf       (wdog_ovf),
   .reg_uv         (reg_uv),
   .mode_o         (mode_o),
   .reg_en         (reg_en),
   .bus_state      (bus_state),
   .wd_mode        (wd_mode),
   .rst_out_n      (rst_out_n),
   .limp_n         (limp_n),
   .int_hold_hi    (int_hold_hi)
);

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;

   localparam int CLK_PERIOD = 10;
   localparam int LONG_C  = 20;
   localparam int SHORT_C = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bat_below_off = 1'b0, bat_above_on = 1'b0;
   logic       temp_above_act = 1'b0, temp_below_rel = 1'b0;
   logic [1:0] mode_req = 2'b00;
   logic       int_line = 1'b1;
   logic [1:0] wake_en = 2'b00, wake_evt = 2'b00;
   logic       wake_pend = 1'b0, wdog_ovf = 1'b0, reg_uv = 1'b0;
   logic       bus_lp_sel = 1'b0, wd_dis = 1'b0, wd_run_sel = 1'b0;
   logic [1:0] wd_norm_sel = 2'b00;
   logic       rst_long_sel = 1'b1;
   logic [2:0] mode_o;
   logic       reg_en, rst_out_n, limp_n, int_hold_hi;
   logic [1:0] bus_state, wd_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_supervisor #(
      .WAKE_W(2), .RST_LONG_CYC(LONG_C), .RST_SHORT_CYC(SHORT_C)
   ) i_pwr_supervisor (
      .clk(clk), .rst_n(rst_n), .bat_below_off(bat_below_off), .bat_above_on(bat_above_on),
      .temp_above_act(temp_above_act), .temp_below_rel(temp_below_rel), .mode_req(mode_req),
      .int_line(int_line), .wake_en(wake_en), .wake_pend(wake_pend), .wake_evt(wake_evt),
      .wdog_ovf(wdog_ovf), .reg_uv(reg_uv), .bus_lp_sel(bus_lp_sel), .wd_dis(wd_dis),
      .wd_run_sel(wd_run_sel), .wd_norm_sel(wd_norm_sel), .rst_long_sel(rst_long_sel),
      .mode_o(mode_o), .reg_en(reg_en), .bus_state(bus_state), .wd_mode(wd_mode),
      .rst_out_n(rst_out_n), .limp_n(limp_n), .int_hold_hi(int_hold_hi)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic pulse_len(output int n);
      n = 0;
      while (!rst_out_n && n < 1000) begin
         n++;
         step();
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #(CLK_PERIOD*3);
      chk("R1", "mode", mode_o, 0);
      chk("R1", "reg_en", reg_en, 0);
      chk("R1", "bus", bus_state, 3);
      chk("R1", "wd", wd_mode, 0);
      chk("R1", "rst_out_n", rst_out_n, 0);
      chk("R1", "int_hold_hi", int_hold_hi, 1);
      chk("R1", "limp_n", limp_n, 1);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R1", "mode stays off", mode_o, 0);
   endtask

   task automatic t_power_up();
      int n;
      rst_long_sel = 1'b1;
      bat_above_on = 1'b1;
      step();
      chk("R3", "mode after power-on", mode_o, 1);
      pulse_len(n);
      chk("R3", "long pulse", n, LONG_C);
      bat_below_off = 1'b1;
      step();
      chk("R2", "battery loss from standby", mode_o, 0);
      bat_below_off = 1'b0;
      rst_long_sel  = 1'b0;
      step();
      chk("R3", "mode after second power-on", mode_o, 1);
      pulse_len(n);
      chk("R3", "short pulse", n, SHORT_C);
   endtask

   task automatic t_mode_req();
      mode_req = 2'b10;
      step();
      chk("R4", "standby to normal", mode_o, 2);
      chk("R4", "no pulse entering normal", rst_out_n, 1);
      mode_req = 2'b11;
      step();
      chk("R4", "11 keeps normal", mode_o, 2);
      mode_req = 2'b00;
      step();
      chk("R4", "normal to standby", mode_o, 1);
      chk("R4", "no pulse leaving normal", rst_out_n, 1);
      mode_req = 2'b11;
      step();
      chk("R4", "11 enters normal", mode_o, 2);
      mode_req = 2'b00;
      step();
   endtask

   task automatic t_sleep_guard();
      mode_req = 2'b01;
      wake_en  = 2'b00;
      step();
      chk("R5", "no wake enabled ignored", mode_o, 1);
      wake_en = 2'b01; wake_pend = 1'b1;
      step();
      chk("R5", "pending wake ignored", mode_o, 1);
      wake_pend = 1'b0; int_line = 1'b0;
      step();
      chk("R5", "interrupt low ignored", mode_o, 1);
      int_line = 1'b1;
      step();
      chk("R5", "sleep entered", mode_o, 3);
      chk("R6", "sleep reg_en", reg_en, 0);
      chk("R6", "sleep rst_out_n", rst_out_n, 0);
      chk("R6", "sleep wd", wd_mode, 0);
   endtask

   task automatic t_sleep_wake();
      int n;
      mode_req = 2'b00;
      wake_evt = 2'b10;
      step();
      chk("R6", "disabled wake ignored", mode_o, 3);
      wake_evt = 2'b01;
      step();
      wake_evt = 2'b00;
      chk("R6", "enabled wake to standby", mode_o, 1);
      pulse_len(n);
      chk("R6", "wake pulse", n, SHORT_C);
   endtask

   task automatic t_normal_reset();
      int n;
      mode_req = 2'b10;
      step();
      chk("R7", "in normal", mode_o, 2);
      wdog_ovf = 1'b1;
      step();
      wdog_ovf = 1'b0;
      mode_req = 2'b00;
      chk("R7", "watchdog overflow to standby", mode_o, 1);
      pulse_len(n);
      chk("R7", "overflow pulse", n, SHORT_C);
      mode_req = 2'b10;
      step();
      mode_req = 2'b01;
      reg_uv   = 1'b1;
      step();
      reg_uv   = 1'b0;
      mode_req = 2'b00;
      chk("R7", "undervoltage beats sleep request", mode_o, 1);
      chk("R7", "undervoltage pulse low", rst_out_n, 0);
      pulse_len(n);
   endtask

   task automatic t_overtemp();
      int n;
      temp_above_act = 1'b1;
      step();
      temp_above_act = 1'b0;
      chk("R8", "standby to overtemp", mode_o, 4);
      chk("R8", "overtemp reg_en", reg_en, 0);
      chk("R8", "overtemp limp_n", limp_n, 0);
      chk("R8", "overtemp bus", bus_state, 3);
      chk("R8", "overtemp wd", wd_mode, 0);
      mode_req = 2'b10;
      step();
      chk("R9", "overtemp held without release", mode_o, 4);
      mode_req = 2'b00;
      temp_below_rel = 1'b1;
      step();
      temp_below_rel = 1'b0;
      chk("R9", "release to standby", mode_o, 1);
      pulse_len(n);
      chk("R9", "release pulse", n, SHORT_C);
      mode_req = 2'b10;
      step();
      temp_above_act = 1'b1;
      wdog_ovf = 1'b1;
      step();
      temp_above_act = 1'b0;
      wdog_ovf = 1'b0;
      mode_req = 2'b00;
      chk("R8", "overtemp beats reset event", mode_o, 4);
      temp_below_rel = 1'b1;
      bat_below_off  = 1'b1;
      step();
      temp_below_rel = 1'b0;
      chk("R2", "battery loss beats release", mode_o, 0);
      bat_below_off = 1'b0;
      step();
      chk("R3", "repower to standby", mode_o, 1);
      pulse_len(n);
   endtask

   task automatic t_bus_wd();
      bus_lp_sel = 1'b1; wd_run_sel = 1'b1; wd_dis = 1'b0;
      settle();
      chk("R10", "standby bus lp", bus_state, 1);
      chk("R11", "standby wd timeout", wd_mode, 1);
      wd_dis = 1'b1; bus_lp_sel = 1'b0;
      settle();
      chk("R10", "standby bus off", bus_state, 2);
      chk("R11", "standby wd disabled", wd_mode, 0);
      wd_dis = 1'b0; wd_run_sel = 1'b0;
      settle();
      chk("R11", "standby wd not selected", wd_mode, 0);
      mode_req = 2'b10;
      step();
      chk("R10", "normal bus active", bus_state, 0);
      chk("R11", "normal wd off", wd_mode, 0);
      bus_lp_sel = 1'b1; wd_norm_sel = 2'b10;
      settle();
      chk("R10", "normal bus lp", bus_state, 1);
      chk("R11", "normal wd window", wd_mode, 2);
      wd_norm_sel = 2'b01;
      settle();
      chk("R11", "normal wd timeout", wd_mode, 1);
      wd_dis = 1'b1;
      settle();
      chk("R11", "normal wd disabled", wd_mode, 0);
      bat_below_off = 1'b1;
      step();
      chk("R2", "battery loss from normal", mode_o, 0);
   endtask

   initial begin
      t_reset();
      t_power_up();
      t_mode_req();
      t_sleep_guard();
      t_sleep_wake();
      t_normal_reset();
      t_overtemp();
      t_bus_wd();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD*100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule